// File: doc/BRIEF.md
# Auto-Increment Register Bank for a Four-Channel Converter

This block is the byte-wide register bank that sits behind the serial-bus slave of a small multi-channel 12-bit converter. A bus front end, which has already decoded the bit-level protocol, hands it three kinds of single-cycle strobes. An address strobe loads the register pointer. A write strobe stores a data byte at the pointer. A read strobe returns the byte at the pointer. Bit 7 of the address byte is a flag and is not part of the address. When the flag is set, each read steps the pointer so that a host can pull several bytes in one burst.

The map has 23 byte registers, at addresses 0x00 to 0x16. Two control bytes sit at the bottom of the map. Above them come the read-only result bytes, one upper/lower pair per channel. Above those are twelve further configuration bytes, and the reset register is at the top. The converter core writes each channel's result through its own update strobe. The bank stores the result left-justified in 16 bits. The control byte at 0x00 is decoded and driven to the core as a mode field and a channel select. Writing the magic byte 0xAA to the reset register returns every stored register to its default.

Top module: `arf_regbank`

## Requirements
- R1: After rst_n is released, all 23 registers (0x00–0x16) read 0x00, and mode_o and chsel_o are zero.
- R2: On an address strobe, addr_byte[6:0] becomes the pointer and addr_byte[7] becomes the auto-increment flag.
- R3: A read strobe with the flag set steps the pointer by one. From 0x16 or any higher address, the step goes to 0x00. Write strobes never move the pointer.
- R4: With the flag clear, the pointer stays put and repeated reads return the same register.
- R5: Addresses 0x00, 0x01 and 0x0A–0x15 store the written byte and return it when read.
- R6: Writes to 0x02–0x09 and to addresses above 0x16 change no register. Register 0x16 always reads 0x00.
- R7: A read from any address in 0x17–0x7F returns 0x00.
- R8: Channel n (0–3) reads its upper byte at 0x02+2n as result[11:4] and its lower byte at 0x03+2n as {result[3:0], 4'b0000}.
- R9: A pulse on res_upd[n] loads only channel n from res_word[12n+11:12n]. The other channels keep their values.
- R10: Writing 0xAA to 0x16 clears all configuration and result registers at that edge. Any other value written there has no effect. The clear wins over a result update in the same cycle.
- R11: mode_o is bits 7:2 and chsel_o is bits 1:0 of register 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_stb | input | 1 | Address byte valid |
| addr_byte | input | 8 | Bit 7 auto-increment flag, bits 6:0 register address |
| wr_stb | input | 1 | Data write strobe |
| wr_byte | input | 8 | Data byte to write at the pointer |
| rd_stb | input | 1 | Data read strobe |
| rd_byte | output | 8 | Byte read at the last read strobe |
| res_upd | input | 4 | Per-channel result load strobe |
| res_word | input | 48 | Four 12-bit results, channel n in bits 12n+11:12n |
| mode_o | output | 6 | Mode field of register 0x00 |
| chsel_o | output | 2 | Channel select of register 0x00 |

## Verification
Every result here is due one clock edge after its stimulus. rd_byte holds the register's value from before the edge that carries the read strobe. A write, an address load, a result update or a soft reset is visible to a read strobed in the following cycle. The bench drives each strobe on the falling edge for exactly one rising edge and samples rd_byte, mode_o and chsel_o on the next falling edge. Each comparison therefore lands half a cycle after the edge that produced the value. The bench keeps its own model of all 23 registers, built from the requirements, and sweeps the whole map after every change.

// File: rtl/arf_pkg.sv
package arf_pkg;
   typedef logic [7:0] byte_t;
   // region of the map the pointer currently addresses
   typedef enum logic [2:0] {
      RG_CTL  = 3'd0,
      RG_RES  = 3'd1,
      RG_CFG  = 3'd2,
      RG_RST  = 3'd3,
      RG_NONE = 3'd4
   } region_e;
endpackage

// File: rtl/arf_pointer.sv
module arf_pointer #(
   parameter int PTR_W = 7,
   parameter int LAST  = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PTR_W:0]   load_byte,
   input  logic             step,
   output logic [PTR_W-1:0] ptr_o,
   output logic             inc_o
);
   localparam logic [PTR_W-1:0] LAST_P = PTR_W'(LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_o <= '0;
         inc_o <= 1'b0;
      end else if (load) begin
         ptr_o <= load_byte[PTR_W-1:0];
         inc_o <= load_byte[PTR_W];
      end else if (step && inc_o) begin
         ptr_o <= (ptr_o >= LAST_P) ? '0 : ptr_o + 1'b1;
      end
   end
endmodule

// File: rtl/arf_result_bank.sv
module arf_result_bank #(
   parameter int NUM_CH = 4,
   parameter int RES_W  = 12,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int PAD   = 16 - RES_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic [NUM_CH-1:0]       upd,
   input  logic [NUM_CH*RES_W-1:0] res_in,
   input  logic [CH_W-1:0]         sel_ch,
   input  logic                    sel_low,
   output arf_pkg::byte_t          byte_o
);
   logic [RES_W-1:0] res_q [NUM_CH];
   logic [RES_W-1:0] sel_res;
   logic [15:0]      word;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       res_q[ch] <= '0;
         else if (clr)     res_q[ch] <= '0;
         else if (upd[ch]) res_q[ch] <= res_in[ch*RES_W +: RES_W];
      end
   end

   assign sel_res = res_q[sel_ch];

   // left-justify the result within the 16-bit byte pair
   if (PAD > 0) begin : g_pad
      assign word = {sel_res, {PAD{1'b0}}};
   end else begin : g_nopad
      assign word = sel_res;
   end

   assign byte_o = sel_low ? word[7:0] : word[15:8];
endmodule

// File: rtl/arf_config_bank.sv
module arf_config_bank #(
   parameter int N_REG  = 14,
   localparam int IDX_W = $clog2(N_REG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  arf_pkg::byte_t   wdata,
   output arf_pkg::byte_t   rdata,
   output arf_pkg::byte_t   ctl0_o
);
   arf_pkg::byte_t cfg_q [N_REG];

   for (genvar i = 0; i < N_REG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          cfg_q[i] <= '0;
         else if (clr)                        cfg_q[i] <= '0;
         else if (we && idx == IDX_W'(i))     cfg_q[i] <= wdata;
      end
   end

   assign rdata  = cfg_q[idx];
   assign ctl0_o = cfg_q[0];
endmodule

// File: rtl/arf_regbank.sv
module arf_regbank #(
   parameter int             NUM_CH    = 4,
   parameter int             RES_W     = 12,
   parameter int             EXTRA_CFG = 4,
   parameter logic [7:0]     MAGIC     = 8'hAA
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    addr_stb,
   input  logic [7:0]              addr_byte,
   input  logic                    wr_stb,
   input  logic [7:0]              wr_byte,
   input  logic                    rd_stb,
   output logic [7:0]              rd_byte,
   input  logic [NUM_CH-1:0]       res_upd,
   input  logic [NUM_CH*RES_W-1:0] res_word,
   output logic [5:0]              mode_o,
   output logic [1:0]              chsel_o
);
   import arf_pkg::*;

   localparam int PTR_W    = 7;
   localparam int N_CTL    = 2;
   localparam int RES_BASE = N_CTL;
   localparam int RES_LAST = RES_BASE + 2*NUM_CH - 1;
   localparam int CFG_BASE = RES_LAST + 1;
   localparam int N_HI_CFG = 2*NUM_CH + EXTRA_CFG;
   localparam int RST_ADDR = CFG_BASE + N_HI_CFG;
   localparam int N_CFG    = N_CTL + N_HI_CFG;
   localparam int IDX_W    = $clog2(N_CFG);
   localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   if (NUM_CH < 1 || NUM_CH > 4) begin : g_bad_ch
      $error("arf_regbank: NUM_CH must be 1..4");
   end
   if (RES_W < 8 || RES_W > 16) begin : g_bad_res
      $error("arf_regbank: RES_W must be 8..16");
   end
   if (RST_ADDR >= (1 << PTR_W)) begin : g_bad_map
      $error("arf_regbank: register map exceeds pointer range");
   end

   logic [PTR_W-1:0] ptr_q;
   logic             inc_q;
   region_e          region;
   logic [IDX_W-1:0] cfg_idx;
   logic [CH_W:0]    res_off;
   byte_t            cfg_rdata, res_byte, ctl0, rd_mux;
   logic             soft_rst, cfg_we;

   arf_pointer #(.PTR_W(PTR_W), .LAST(RST_ADDR)) ptr_i (
      .clk(clk), .rst_n(rst_n), .load(addr_stb), .load_byte(addr_byte),
      .step(rd_stb), .ptr_o(ptr_q), .inc_o(inc_q)
   );

   always_comb begin
      if (ptr_q < PTR_W'(RES_BASE))        region = RG_CTL;
      else if (ptr_q <= PTR_W'(RES_LAST))  region = RG_RES;
      else if (ptr_q <  PTR_W'(RST_ADDR))  region = RG_CFG;
      else if (ptr_q == PTR_W'(RST_ADDR))  region = RG_RST;
      else                                 region = RG_NONE;
   end

   assign cfg_idx  = (region == RG_CTL) ? IDX_W'(ptr_q)
                                        : IDX_W'(ptr_q - PTR_W'(CFG_BASE - N_CTL));
   assign res_off  = (CH_W+1)'(ptr_q - PTR_W'(RES_BASE));
   assign soft_rst = wr_stb && (region == RG_RST) && (wr_byte == MAGIC);
   assign cfg_we   = wr_stb && (region == RG_CTL || region == RG_CFG);

   arf_config_bank #(.N_REG(N_CFG)) cfg_i (
      .clk(clk), .rst_n(rst_n), .clr(soft_rst), .we(cfg_we), .idx(cfg_idx),
      .wdata(wr_byte), .rdata(cfg_rdata), .ctl0_o(ctl0)
   );

   arf_result_bank #(.NUM_CH(NUM_CH), .RES_W(RES_W)) res_i (
      .clk(clk), .rst_n(rst_n), .clr(soft_rst), .upd(res_upd), .res_in(res_word),
      .sel_ch(res_off[CH_W:1]), .sel_low(res_off[0]), .byte_o(res_byte)
   );

   always_comb begin
      unique case (region)
         RG_CTL, RG_CFG: rd_mux = cfg_rdata;
         RG_RES:         rd_mux = res_byte;
         default:        rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rd_byte <= '0;
      else if (rd_stb) rd_byte <= rd_mux;
   end

   assign mode_o  = ctl0[7:2];
   assign chsel_o = ctl0[1:0];
endmodule

module arf_regbank_chk #(
   parameter int LAST = 22
) (
   input logic       clk,
   input logic       rst_n,
   input logic       addr_stb,
   input logic [7:0] addr_byte,
   input logic       rd_stb,
   input logic       wr_stb,
   input logic [7:0] wr_byte,
   input logic [7:0] rd_byte,
   input logic [6:0] ptr,
   input logic       inc,
   input logic [5:0] mode_o,
   input logic [1:0] chsel_o
);
   localparam logic [6:0] LAST_P = 7'(LAST);

   // R2
   addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_stb |=> (ptr == $past(addr_byte[6:0])) && (inc == $past(addr_byte[7])));

   // R4
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !addr_stb && !inc) |=> ptr == $past(ptr));

   // R3
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !addr_stb && inc && ptr < LAST_P) |=> ptr == 7'($past(ptr) + 7'd1));

   // R3
   ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !addr_stb && inc && ptr >= LAST_P) |=> ptr == 7'd0);

   // R7
   oor_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && ptr > LAST_P) |=> rd_byte == 8'h00);

   // R6
   rst_reg_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && ptr == LAST_P) |=> rd_byte == 8'h00);

   // R8
   low_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && ptr[0] && ptr >= 7'd3 && ptr <= 7'd9) |=> rd_byte[3:0] == 4'h0);

   // R10
   soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && ptr == LAST_P && wr_byte == 8'hAA) |=> (mode_o == 6'd0) && (chsel_o == 2'd0));
endmodule

bind arf_regbank arf_regbank_chk chk_i (
   .clk(clk), .rst_n(rst_n), .addr_stb(addr_stb), .addr_byte(addr_byte),
   .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_byte(wr_byte), .rd_byte(rd_byte),
   .ptr(ptr_q), .inc(inc_q), .mode_o(mode_o), .chsel_o(chsel_o)
);

// File: tb/arf_regbank_tb.sv
module arf_regbank_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_CH = 4;
   localparam int RES_W  = 12;
   localparam int N_ADDR = 23;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic addr_stb = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
   logic [7:0] addr_byte = '0, wr_byte = '0;
   logic [7:0] rd_byte;
   logic [NUM_CH-1:0] res_upd = '0;
   logic [NUM_CH*RES_W-1:0] res_word = '0;
   logic [5:0] mode_o;
   logic [1:0] chsel_o;

   int tests = 0, fails = 0;
   bit done = 0;
   int model [N_ADDR];

   always #(CLK_PERIOD/2) clk = ~clk;

   arf_regbank dut_i (
      .clk(clk), .rst_n(rst_n), .addr_stb(addr_stb), .addr_byte(addr_byte),
      .wr_stb(wr_stb), .wr_byte(wr_byte), .rd_stb(rd_stb), .rd_byte(rd_byte),
      .res_upd(res_upd), .res_word(res_word), .mode_o(mode_o), .chsel_o(chsel_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_ptr(input logic [7:0] a);
      @(negedge clk); addr_stb = 1'b1; addr_byte = a;
      @(negedge clk); addr_stb = 1'b0;
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk); wr_stb = 1'b1; wr_byte = d;
      @(negedge clk); wr_stb = 1'b0;
   endtask

   task automatic rd(output logic [7:0] v);
      @(negedge clk); rd_stb = 1'b1;
      @(negedge clk); rd_stb = 1'b0; v = rd_byte;
   endtask

   task automatic wr_at(input int a, input logic [7:0] d);
      set_ptr(8'(a)); wr(d);
   endtask

   function automatic bit writable(input int a);
      return (a <= 1) || (a >= 10 && a <= 21);
   endfunction

   task automatic set_result(input int c, input int r);
      model[2 + 2*c] = (r >> 4) & 255;
      model[3 + 2*c] = (r & 15) << 4;
   endtask

   task automatic upd(input int c, input int r);
      @(negedge clk); res_word[c*RES_W +: RES_W] = RES_W'(r); res_upd = NUM_CH'(1 << c);
      @(negedge clk); res_upd = '0;
      set_result(c, r);
   endtask

   task automatic read_all(input string req);
      logic [7:0] v;
      set_ptr(8'h80);
      for (int i = 0; i < N_ADDR; i++) begin
         rd(v);
         chk($sformatf("%s addr %0h", req, i), int'(v), model[i]);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      for (int i = 0; i < N_ADDR; i++) model[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 mode_o", int'(mode_o), 0);
      chk("R1 chsel_o", int'(chsel_o), 0);
      read_all("R1");

      // R5 writable registers
      for (int a = 0; a < N_ADDR; a++)
         if (writable(a)) begin
            wr_at(a, 8'((a*29 + 7) & 255));
            model[a] = (a*29 + 7) & 255;
         end
      read_all("R5");
      // R11 decode of register 0x00
      chk("R11 mode_o", int'(mode_o), model[0] >> 2);
      chk("R11 chsel_o", int'(chsel_o), model[0] & 3);

      // R6 read-only data writes ignored
      for (int a = 2; a <= 9; a++) wr_at(a, 8'h5A);
      read_all("R6");
      // R10 non-magic value to reset register has no effect
      wr_at(22, 8'h55);
      read_all("R10 nonmagic");

      // R8 packing and R9 per-channel strobe
      for (int k = 0; k < 16; k++)
         for (int c = 0; c < NUM_CH; c++) begin
            upd(c, (k*273 + c*1111) & 12'hFFF);
            read_all("R8/R9");
         end

      // R4 hold pointer when flag clear
      set_ptr(8'h04);
      for (int i = 0; i < 3; i++) begin
         rd(v); chk("R4 repeat read", int'(v), model[4]);
      end
      // R3 step with flag set
      set_ptr(8'h85);
      rd(v); chk("R3 first", int'(v), model[5]);
      rd(v); chk("R3 step", int'(v), model[6]);
      // R2 address and flag loaded
      set_ptr(8'h8A);
      rd(v); chk("R2 load", int'(v), model[10]);
      rd(v); chk("R2 flag", int'(v), model[11]);

      // R7 out-of-range reads
      for (int a = 23; a < 128; a++) begin
         set_ptr(8'(a)); rd(v); chk("R7 oor read", int'(v), 0);
      end
      // R6 out-of-range writes ignored
      wr_at(8'h17, 8'hFF); wr_at(8'h40, 8'hFF); wr_at(8'h7F, 8'hFF);
      read_all("R6 oor write");

      // R3 wrap from 0x16 and from above
      set_ptr(8'h96);
      rd(v); chk("R6 reset reg read", int'(v), 0);
      rd(v); chk("R3 wrap 0x16", int'(v), model[0]);
      set_ptr(8'hFF);
      rd(v); chk("R7 0x7F", int'(v), 0);
      rd(v); chk("R3 wrap 0x7F", int'(v), model[0]);

      // R10 soft reset, same cycle as a result update
      set_ptr(8'h16);
      @(negedge clk);
      wr_stb = 1'b1; wr_byte = 8'hAA;
      res_word[0 +: RES_W] = 12'hABC; res_upd = 4'b0001;
      @(negedge clk);
      wr_stb = 1'b0; res_upd = '0;
      for (int i = 0; i < N_ADDR; i++) model[i] = 0;
      chk("R10 mode_o", int'(mode_o), 0);
      chk("R10 chsel_o", int'(chsel_o), 0);
      read_all("R10");

      // R11 field split
      wr_at(0, 8'hB7);
      chk("R11 mode_o B7", int'(mode_o), 6'h2D);
      chk("R11 chsel_o B7", int'(chsel_o), 3);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule